// File: doc/BRIEF.md
# SPI Shared-Pad Router

This block sits between an SPI core and the four pads that the core can borrow from general-purpose I/O: the serial clock, two data lines and the slave select. The core's enable, role and pin-mode bits decide, cycle by cycle, which of these pads the SPI owns. For each pad they also decide whether the SPI drives it or listens to it, and which pad input is passed on to the core as receive data, clock and select. The first data pad carries data from master to slave and the second carries data from slave to master, except in single-wire mode. In single-wire mode one data pad is shared in both directions, and which pad that is depends on the role.

The slave-select pad has three uses in master mode: it can be left to general-purpose I/O, it can act as a mode-fault input, or it can be driven as a select output that follows the core's transfer-active signal. In the mode-fault role, a low level seen on a clock edge sets a sticky fault flag. From the next cycle the flag pulls down the master-active indication, which the core uses to stop driving.

The routing is purely combinational. The fault flag is the only state.

Top module: `spi_pad_router`

## Requirements
- R1: With `cfg_enable` low, every `spi_own_*` and every `pad_*_oe` output is 0.
- R2: Enabled as master, the clock pad has `pad_sclk_oe`=1 and `pad_sclk_out`=`core_sclk_out`. Enabled as slave, `pad_sclk_oe`=0 and `core_sclk_in`=`pad_sclk_in`. The SPI owns the clock pad whenever it is enabled.
- R3: Master with `cfg_single_wire`=0: data pad 0 is owned and driven with `core_tx_data`. Data pad 1 is owned, is not driven, and its input appears on `core_rx_data`.
- R4: Slave with `cfg_single_wire`=0: data pad 0 is owned, is not driven, and its input appears on `core_rx_data`. Data pad 1 is owned and driven with `core_tx_data`.
- R5: Master with `cfg_single_wire`=1: data pad 0 is owned, its output enable equals `cfg_line_drive`, and its input appears on `core_rx_data`. Data pad 1 is released (not owned, not driven).
- R6: Slave with `cfg_single_wire`=1: data pad 1 is owned, its output enable equals `cfg_line_drive`, and its input appears on `core_rx_data`. Data pad 0 is released.
- R7: As slave, the select pad is owned, is not driven, and `core_sel_n`=`pad_sel_in` (active low). In every other mode `core_sel_n` is 1.
- R8: Master with `cfg_fault_en`=0: the select pad is released.
- R9: Master with `cfg_fault_en`=1 and `cfg_sel_drive`=1: the select pad is owned and driven, and `pad_sel_out` is the inverse of `core_xfer_active`.
- R10: Master with `cfg_fault_en`=1 and `cfg_sel_drive`=0: the select pad is an owned input. A 0 on `pad_sel_in` at a clock edge sets `fault_flag` after that edge, and the flag stays set until it is cleared.
- R11: `fault_clear` high at a clock edge clears `fault_flag` after that edge, unless a fault is detected at the same edge, in which case the flag is set.
- R12: `master_active` is 1 exactly when the block is enabled as master and `fault_flag` is 0, so it falls in the cycle after a fault is detected.
- R13: Any pad output value whose output enable is 0 is driven as 0. When the SPI is not receiving through a pad, `core_rx_data` and `core_sclk_in` are 0.
- R14: After reset `fault_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | SPI enable |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_single_wire | input | 1 | Single-wire bidirectional data mode |
| cfg_line_drive | input | 1 | Output enable of the shared data line in single-wire mode |
| cfg_fault_en | input | 1 | Master: select pad used by SPI (fault input or select output) |
| cfg_sel_drive | input | 1 | Master with fault enable: 1 = select output, 0 = fault input |
| core_sclk_out | input | 1 | Serial clock from the core (master) |
| core_tx_data | input | 1 | Transmit bit from the core |
| core_xfer_active | input | 1 | Master transfer in progress |
| fault_clear | input | 1 | Clear strobe for the fault flag |
| pad_sclk_in | input | 1 | Clock pad input |
| pad_d0_in | input | 1 | Data pad 0 input |
| pad_d1_in | input | 1 | Data pad 1 input |
| pad_sel_in | input | 1 | Select pad input |
| spi_own_sclk | output | 1 | SPI owns the clock pad |
| pad_sclk_oe | output | 1 | Clock pad output enable |
| pad_sclk_out | output | 1 | Clock pad output value |
| spi_own_d0 | output | 1 | SPI owns data pad 0 |
| pad_d0_oe | output | 1 | Data pad 0 output enable |
| pad_d0_out | output | 1 | Data pad 0 output value |
| spi_own_d1 | output | 1 | SPI owns data pad 1 |
| pad_d1_oe | output | 1 | Data pad 1 output enable |
| pad_d1_out | output | 1 | Data pad 1 output value |
| spi_own_sel | output | 1 | SPI owns the select pad |
| pad_sel_oe | output | 1 | Select pad output enable |
| pad_sel_out | output | 1 | Select pad output value |
| core_sclk_in | output | 1 | Serial clock to the core (slave) |
| core_rx_data | output | 1 | Receive bit to the core |
| core_sel_n | output | 1 | Active-low select to the core |
| fault_flag | output | 1 | Sticky mode-fault flag |
| master_active | output | 1 | Master mode in effect and no fault |

## Verification
Every pad ownership, enable, output value and core-side input is combinational, so it is due in the same cycle as the configuration and pad levels that produce it. The fault flag and `master_active` change one edge after the sampled select level or the clear strobe. The bench changes its inputs just after a rising edge and compares every output with its reference model at the following falling edge. The reference updates its own flag on the same rising edge as the design, so a registered result is compared one cycle after its cause and a combinational result in the cycle of its cause.

// File: rtl/spi_pad_router.sv
module spi_pad_router (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_enable,
  input  logic cfg_master,
  input  logic cfg_single_wire,
  input  logic cfg_line_drive,
  input  logic cfg_fault_en,
  input  logic cfg_sel_drive,
  input  logic core_sclk_out,
  input  logic core_tx_data,
  input  logic core_xfer_active,
  input  logic fault_clear,
  input  logic pad_sclk_in,
  input  logic pad_d0_in,
  input  logic pad_d1_in,
  input  logic pad_sel_in,
  output logic spi_own_sclk,
  output logic pad_sclk_oe,
  output logic pad_sclk_out,
  output logic spi_own_d0,
  output logic pad_d0_oe,
  output logic pad_d0_out,
  output logic spi_own_d1,
  output logic pad_d1_oe,
  output logic pad_d1_out,
  output logic spi_own_sel,
  output logic pad_sel_oe,
  output logic pad_sel_out,
  output logic core_sclk_in,
  output logic core_rx_data,
  output logic core_sel_n,
  output logic fault_flag,
  output logic master_active
);

  logic is_master, is_slave, duplex;
  logic sel_as_fault, sel_as_output, fault_seen;

  assign is_master = cfg_enable & cfg_master;
  assign is_slave  = cfg_enable & ~cfg_master;
  assign duplex    = ~cfg_single_wire;

  assign spi_own_sclk = cfg_enable;
  assign pad_sclk_oe  = is_master;
  assign pad_sclk_out = is_master & core_sclk_out;
  assign core_sclk_in = is_slave & pad_sclk_in;

  assign spi_own_d0 = is_master | (is_slave & duplex);
  assign pad_d0_oe  = is_master & (duplex | cfg_line_drive);
  assign pad_d0_out = pad_d0_oe & core_tx_data;

  assign spi_own_d1 = is_slave | (is_master & duplex);
  assign pad_d1_oe  = is_slave & (duplex | cfg_line_drive);
  assign pad_d1_out = pad_d1_oe & core_tx_data;

  always_comb begin
    core_rx_data = 1'b0;
    if (is_master)
      core_rx_data = cfg_single_wire ? pad_d0_in : pad_d1_in;
    else if (is_slave)
      core_rx_data = cfg_single_wire ? pad_d1_in : pad_d0_in;
  end

  assign sel_as_fault  = is_master & cfg_fault_en & ~cfg_sel_drive;
  assign sel_as_output = is_master & cfg_fault_en & cfg_sel_drive;

  assign spi_own_sel = is_slave | sel_as_fault | sel_as_output;
  assign pad_sel_oe  = sel_as_output;
  assign pad_sel_out = sel_as_output & ~core_xfer_active;
  assign core_sel_n  = is_slave ? pad_sel_in : 1'b1;

  assign fault_seen = sel_as_fault & ~pad_sel_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fault_flag <= 1'b0;
    else if (fault_seen)
      fault_flag <= 1'b1;
    else if (fault_clear)
      fault_flag <= 1'b0;
  end

  assign master_active = is_master & ~fault_flag;

endmodule

module spi_pad_router_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_enable,
  input logic cfg_master,
  input logic cfg_single_wire,
  input logic cfg_line_drive,
  input logic cfg_fault_en,
  input logic cfg_sel_drive,
  input logic core_xfer_active,
  input logic fault_clear,
  input logic pad_sel_in,
  input logic spi_own_sclk,
  input logic pad_sclk_oe,
  input logic spi_own_d0,
  input logic pad_d0_oe,
  input logic spi_own_d1,
  input logic pad_d1_oe,
  input logic spi_own_sel,
  input logic pad_sel_oe,
  input logic pad_sel_out,
  input logic fault_flag,
  input logic master_active
);

  assert_disabled_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |-> !(spi_own_sclk | spi_own_d0 | spi_own_d1 | spi_own_sel |
                      pad_sclk_oe | pad_d0_oe | pad_d1_oe | pad_sel_oe));

  assert_single_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && cfg_single_wire) |-> !(pad_d0_oe && pad_d1_oe) && !(spi_own_d0 && spi_own_d1));

  assert_sel_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && cfg_master && cfg_fault_en && cfg_sel_drive) |->
      (pad_sel_oe && pad_sel_out == !core_xfer_active));

  assert_fault_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && cfg_master && cfg_fault_en && !cfg_sel_drive && !pad_sel_in) |=> fault_flag);

  assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_flag && !fault_clear) |=> fault_flag);

  assert_fault_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_clear && !(cfg_enable && cfg_master && cfg_fault_en && !cfg_sel_drive && !pad_sel_in))
      |=> !fault_flag);

  assert_master_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fault_flag |-> !master_active);

endmodule

bind spi_pad_router spi_pad_router_chk u_chk (.*);

// File: tb/spi_pad_router_bench.sv
`timescale 1ns/1ps
module spi_pad_router_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 0, cfg_master = 0, cfg_single_wire = 0, cfg_line_drive = 0;
  logic cfg_fault_en = 0, cfg_sel_drive = 0;
  logic core_sclk_out = 0, core_tx_data = 0, core_xfer_active = 0, fault_clear = 0;
  logic pad_sclk_in = 0, pad_d0_in = 0, pad_d1_in = 0, pad_sel_in = 1;
  logic spi_own_sclk, pad_sclk_oe, pad_sclk_out;
  logic spi_own_d0, pad_d0_oe, pad_d0_out;
  logic spi_own_d1, pad_d1_oe, pad_d1_out;
  logic spi_own_sel, pad_sel_oe, pad_sel_out;
  logic core_sclk_in, core_rx_data, core_sel_n, fault_flag, master_active;

  int n_checks = 0;
  int n_errors = 0;
  logic exp_flag;

  always #5 clk = ~clk;

  spi_pad_router u_spi_pad_router (.*);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_flag <= 1'b0;
    else if (cfg_enable && cfg_master && cfg_fault_en && !cfg_sel_drive && !pad_sel_in) exp_flag <= 1'b1;
    else if (fault_clear) exp_flag <= 1'b0;
  end

  task automatic chk(input string rq, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    if (!cfg_enable) begin
      chk("R1", "own_sclk", spi_own_sclk, 0); chk("R1", "sclk_oe", pad_sclk_oe, 0);
      chk("R1", "own_d0", spi_own_d0, 0);     chk("R1", "d0_oe", pad_d0_oe, 0);
      chk("R1", "own_d1", spi_own_d1, 0);     chk("R1", "d1_oe", pad_d1_oe, 0);
      chk("R1", "own_sel", spi_own_sel, 0);   chk("R1", "sel_oe", pad_sel_oe, 0);
      chk("R13", "rx", core_rx_data, 0);      chk("R13", "sclk_in", core_sclk_in, 0);
      chk("R7", "sel_n", core_sel_n, 1);
    end else begin
      chk("R2", "own_sclk", spi_own_sclk, 1);
      if (cfg_master) begin
        chk("R2", "sclk_oe", pad_sclk_oe, 1); chk("R2", "sclk_out", pad_sclk_out, core_sclk_out);
        chk("R13", "sclk_in", core_sclk_in, 0);
        chk("R7", "sel_n", core_sel_n, 1);
      end else begin
        chk("R2", "sclk_oe", pad_sclk_oe, 0); chk("R13", "sclk_out", pad_sclk_out, 0);
        chk("R2", "sclk_in", core_sclk_in, pad_sclk_in);
      end
      case ({cfg_master, cfg_single_wire})
        2'b10: begin
          chk("R3", "own_d0", spi_own_d0, 1); chk("R3", "d0_oe", pad_d0_oe, 1);
          chk("R3", "d0_out", pad_d0_out, core_tx_data);
          chk("R3", "own_d1", spi_own_d1, 1); chk("R3", "d1_oe", pad_d1_oe, 0);
          chk("R13", "d1_out", pad_d1_out, 0); chk("R3", "rx", core_rx_data, pad_d1_in);
        end
        2'b00: begin
          chk("R4", "own_d0", spi_own_d0, 1); chk("R4", "d0_oe", pad_d0_oe, 0);
          chk("R13", "d0_out", pad_d0_out, 0);
          chk("R4", "own_d1", spi_own_d1, 1); chk("R4", "d1_oe", pad_d1_oe, 1);
          chk("R4", "d1_out", pad_d1_out, core_tx_data); chk("R4", "rx", core_rx_data, pad_d0_in);
        end
        2'b11: begin
          chk("R5", "own_d0", spi_own_d0, 1); chk("R5", "d0_oe", pad_d0_oe, cfg_line_drive);
          chk("R13", "d0_out", pad_d0_out, cfg_line_drive & core_tx_data);
          chk("R5", "own_d1", spi_own_d1, 0); chk("R5", "d1_oe", pad_d1_oe, 0);
          chk("R5", "rx", core_rx_data, pad_d0_in);
        end
        default: begin
          chk("R6", "own_d1", spi_own_d1, 1); chk("R6", "d1_oe", pad_d1_oe, cfg_line_drive);
          chk("R13", "d1_out", pad_d1_out, cfg_line_drive & core_tx_data);
          chk("R6", "own_d0", spi_own_d0, 0); chk("R6", "d0_oe", pad_d0_oe, 0);
          chk("R6", "rx", core_rx_data, pad_d1_in);
        end
      endcase
      if (!cfg_master) begin
        chk("R7", "own_sel", spi_own_sel, 1); chk("R7", "sel_oe", pad_sel_oe, 0);
        chk("R7", "sel_n", core_sel_n, pad_sel_in);
      end else if (!cfg_fault_en) begin
        chk("R8", "own_sel", spi_own_sel, 0); chk("R8", "sel_oe", pad_sel_oe, 0);
      end else if (cfg_sel_drive) begin
        chk("R9", "own_sel", spi_own_sel, 1); chk("R9", "sel_oe", pad_sel_oe, 1);
        chk("R9", "sel_out", pad_sel_out, !core_xfer_active);
      end else begin
        chk("R10", "own_sel", spi_own_sel, 1); chk("R10", "sel_oe", pad_sel_oe, 0);
        chk("R13", "sel_out", pad_sel_out, 0);
      end
    end
    chk("R10/R11", "fault_flag", fault_flag, exp_flag);
    chk("R12", "master_active", master_active, cfg_enable & cfg_master & !exp_flag);
  endtask

  task automatic cycle();
    @(negedge clk);
    compare();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #2000000;
    n_errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R14", "reset fault_flag", fault_flag, 0);
    chk("R14", "reset master_active", master_active, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // directed fault sequence, R10 / R11 / R12
    cfg_enable = 1; cfg_master = 1; cfg_fault_en = 1; cfg_sel_drive = 0; pad_sel_in = 1;
    cycle();
    pad_sel_in = 0; cycle();
    pad_sel_in = 1; cycle();
    cycle();
    fault_clear = 1; pad_sel_in = 0; cycle();
    pad_sel_in = 1; cycle();
    fault_clear = 0; cycle();
    cfg_sel_drive = 1; core_xfer_active = 1; cycle();
    core_xfer_active = 0; cycle();

    for (int i = 0; i < 4000; i++) begin
      if (i % 12 == 0) begin
        cfg_enable      = ($urandom % 5) != 0;
        cfg_master      = $urandom;
        cfg_single_wire = $urandom;
        cfg_line_drive  = $urandom;
        cfg_fault_en    = $urandom;
        cfg_sel_drive   = $urandom;
      end
      core_sclk_out    = $urandom;
      core_tx_data     = $urandom;
      core_xfer_active = $urandom;
      fault_clear      = ($urandom % 6) == 0;
      pad_sclk_in      = $urandom;
      pad_d0_in        = $urandom;
      pad_d1_in        = $urandom;
      pad_sel_in       = ($urandom % 4) != 0;
      cycle();
    end
    finish_run();
  end
endmodule